// File: doc/BRIEF.md
# Filtered I2C Register-Write Target

This block is an I2C target that accepts one register write per bus transaction. It runs on a local clock that is much faster than SCL and never uses SCL as a clock. Both bus lines pass through a two-stage synchronizer and then a counting spike filter. START and STOP conditions and the SCL edges are taken from the filtered levels.

A transaction is a START, then a device-address byte carrying the direction bit, then a register-select byte, then a data byte. The block acknowledges a byte only when everything up to that byte has matched its configured values. After it acknowledges the data byte, it writes that byte out on a single-cycle strobe together with the register select. SDA is open drain: the block only reads it and asks for it to be pulled low. Reads, clock stretching and address auto-increment are not provided.

Top module: `i2c_reg_rx`

## Requirements
- R1: After reset, `sda_pull` and `wr_strobe` are low.
- R2: On each line, a level that differs from the filtered level for fewer than FILTER_LENGTH consecutive local clocks after synchronization leaves the filtered level unchanged. An SCL spike of that length adds no bit. An SDA spike of that length while SCL is high starts no transfer.
- R3: SDA falling while SCL is high (START) begins reception of the address byte. SDA rising while SCL is high (STOP) returns the block to idle with SDA released.
- R4: Bits are taken MSB first on the rising edge of filtered SCL. The first byte holds the device address in bits 7..1 and the direction in bit 0, where 0 means write. The byte is acknowledged only when bits 7..1 equal DEV_ADDR and bit 0 is 0. Otherwise the byte is not acknowledged and the block goes idle.
- R5: The second byte is acknowledged only when it equals REG_ADDR. Otherwise it is not acknowledged and the block goes idle.
- R6: When both earlier bytes matched, the third byte is acknowledged. A `wr_strobe` pulse of exactly one clock then presents that byte on `wr_data` and the register select on `wr_addr`.
- R7: Bytes that follow the data byte in the same transaction are not acknowledged and produce no strobe.
- R8: A repeated START in any state restarts address reception.
- R9: `sda_pull` changes level only while filtered SCL is low. It asserts one clock after the falling edge that ends the eighth bit, holds through the ninth SCL pulse, and releases one clock after the ninth falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus SCL level |
| sda_i | input | 1 | Bus SDA level |
| sda_pull | output | 1 | When high, SDA is to be pulled low |
| wr_strobe | output | 1 | One-cycle register write pulse |
| wr_addr | output | 8 | Register select of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
The assertions assume that a bus master changes SDA only while SCL is low, except at START and STOP. They also assume that every intended bus level lasts well over FILTER_LENGTH plus two local clocks, so the filtered edges keep the order of the real edges. The bench master holds each SCL phase for about two dozen clocks and moves SDA a quarter of a bit after SCL falls. It injects spikes only of two clocks, which is below the filter length. The wired-AND of the master and `sda_pull` is modelled in the bench, so the block's own acknowledge appears on the line it samples.

// File: rtl/i2c_reg_rx.sv
module i2c_reg_rx #(
  parameter logic [6:0] DEV_ADDR      = 7'h2A,
  parameter logic [7:0] REG_ADDR      = 8'h41,
  parameter int         FILTER_LENGTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  output logic       wr_strobe,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);

  localparam int CW = $clog2(FILTER_LENGTH + 1);
  localparam logic [CW-1:0] CMAX = CW'(FILTER_LENGTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_DEV, S_SUB, S_DATA} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_f, sda_f, scl_d, sda_d;
  logic [CW-1:0] scl_cnt, sda_cnt;
  st_t           st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    sub_q;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_det = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_det  = scl_f & scl_d & ~sda_d & sda_f;
  wire dev_ok   = (shreg[7:1] == DEV_ADDR) && !shreg[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_f   <= 1'b1;
      scl_cnt <= '0;
    end else if (scl_s == scl_f) begin
      scl_cnt <= '0;
    end else if (scl_cnt == CMAX) begin
      scl_f   <= scl_s;
      scl_cnt <= '0;
    end else begin
      scl_cnt <= scl_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sda_f   <= 1'b1;
      sda_cnt <= '0;
    end else if (sda_s == sda_f) begin
      sda_cnt <= '0;
    end else if (sda_cnt == CMAX) begin
      sda_f   <= sda_s;
      sda_cnt <= '0;
    end else begin
      sda_cnt <= sda_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      sub_q     <= '0;
      sda_pull  <= 1'b0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_strobe <= 1'b0;
      if (start_det) begin
        st       <= S_DEV;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_f};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          case (st)
            S_DEV:
              if (dev_ok) begin
                sda_pull <= 1'b1;
                bitcnt   <= 4'd9;
              end else begin
                st     <= S_IDLE;
                bitcnt <= '0;
              end
            S_SUB:
              if (shreg == REG_ADDR) begin
                sda_pull <= 1'b1;
                sub_q    <= shreg;
                bitcnt   <= 4'd9;
              end else begin
                st     <= S_IDLE;
                bitcnt <= '0;
              end
            default: begin
              sda_pull  <= 1'b1;
              bitcnt    <= 4'd9;
              wr_strobe <= 1'b1;
              wr_data   <= shreg;
              wr_addr   <= sub_q;
            end
          endcase
        end else if (scl_fall && bitcnt == 4'd9) begin
          sda_pull <= 1'b0;
          bitcnt   <= '0;
          case (st)
            S_DEV:   st <= S_SUB;
            S_SUB:   st <= S_DATA;
            default: st <= S_IDLE;
          endcase
        end
      end
    end

  a_r9_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);

  a_r9_pull_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  a_r3_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull && !wr_strobe));

  a_r2_scl_filter: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_f) |-> ($past(scl_s) == scl_f));

  a_r2_sda_filter: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_f) |-> ($past(sda_s) == sda_f));

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  a_r6_strobe_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_addr == REG_ADDR && sda_pull));

endmodule

// File: tb/sim_i2c_reg_rx.sv
module sim_i2c_reg_rx;
  localparam int CLK_PERIOD = 10;
  localparam int H = 24;
  localparam int Q = 12;
  localparam logic [6:0] DEV = 7'h2A;
  localparam logic [7:0] SUB = 8'h41;
  localparam int NV = 7;
  // {dev byte, sub byte, data byte, ack dev, ack sub, ack data, strobe}
  localparam logic [27:0] VEC [NV] = '{
    {8'h54, 8'h41, 8'hA5, 4'b1111},
    {8'h54, 8'h41, 8'h00, 4'b1111},
    {8'h54, 8'h41, 8'hFF, 4'b1111},
    {8'h56, 8'h41, 8'h12, 4'b0000},
    {8'h55, 8'h41, 8'h12, 4'b0000},
    {8'h54, 8'h40, 8'h12, 4'b1000},
    {8'h54, 8'h41, 8'h81, 4'b1111}
  };

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1, g_scl = 0, g_sda = 0;
  logic sda_pull, wr_strobe;
  logic [7:0] wr_addr, wr_data;
  int checks = 0, failures = 0, nstrobe = 0, dbl = 0;
  logic [7:0] last_data = 0, last_addr = 0;
  logic prev_strobe = 0;

  wire scl_bus = m_scl | g_scl;
  wire sda_bus = m_sda & ~g_sda & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_rx #(.DEV_ADDR(DEV), .REG_ADDR(SUB), .FILTER_LENGTH(3)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .sda_pull(sda_pull), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data));

  always @(negedge clk) begin
    if (wr_strobe) begin
      nstrobe++;
      last_data = wr_data;
      last_addr = wr_addr;
      if (prev_strobe) dbl++;
    end
    prev_strobe = wr_strobe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch && i == 3) begin
        tick(4); g_scl = 1; tick(2); g_scl = 0; tick(Q - 6);
      end else tick(Q);
      m_scl = 1; tick(H); m_scl = 0; tick(Q);
    end
    m_sda = 1; tick(Q);
    m_scl = 1; tick(H/2); ack = !sda_bus; tick(H/2);
    m_scl = 0; tick(Q);
  endtask

  initial begin
    bit a0, a1, a2, a3;
    int s0;
    tick(3);
    chk("R1 sda_pull reset", sda_pull, 0);
    chk("R1 strobe reset", wr_strobe, 0);
    rst_n = 1; tick(10);

    for (int v = 0; v < NV; v++) begin
      s0 = nstrobe;
      i2c_start();
      send_byte(VEC[v][27:20], 0, a0);
      send_byte(VEC[v][19:12], 0, a1);
      send_byte(VEC[v][11:4], 0, a2);
      i2c_stop();
      chk($sformatf("R4 dev ack vec%0d", v), a0, VEC[v][3]);
      chk($sformatf("R5 sub ack vec%0d", v), a1, VEC[v][2]);
      chk($sformatf("R6 data ack vec%0d", v), a2, VEC[v][1]);
      chk($sformatf("R6 strobe count vec%0d", v), nstrobe - s0, VEC[v][0]);
      if (VEC[v][0]) begin
        chk($sformatf("R6 data vec%0d", v), last_data, VEC[v][11:4]);
        chk($sformatf("R6 addr vec%0d", v), last_addr, SUB);
      end
      chk("R3 released after stop", sda_pull, 0);
    end

    // R7: extra byte after the data byte
    s0 = nstrobe;
    i2c_start();
    send_byte(8'h54, 0, a0); send_byte(SUB, 0, a1);
    send_byte(8'h3C, 0, a2); send_byte(8'hC3, 0, a3);
    i2c_stop();
    chk("R7 extra byte nack", a3, 0);
    chk("R7 one strobe", nstrobe - s0, 1);
    chk("R7 data kept", last_data, 8'h3C);

    // R8: repeated start after sub-address
    s0 = nstrobe;
    i2c_start();
    send_byte(8'h54, 0, a0); send_byte(SUB, 0, a1);
    i2c_start();
    send_byte(8'h54, 0, a0); send_byte(SUB, 0, a1); send_byte(8'h6E, 0, a2);
    i2c_stop();
    chk("R8 restart ack dev", a0, 1);
    chk("R8 restart data ack", a2, 1);
    chk("R8 restart data", last_data, 8'h6E);
    chk("R8 restart strobe", nstrobe - s0, 1);

    // R8: repeated start after a non-matching address
    i2c_start();
    send_byte(8'h22, 0, a0);
    i2c_start();
    send_byte(8'h54, 0, a0);
    i2c_stop();
    chk("R8 restart after mismatch", a0, 1);

    // R3: stop mid-transfer, then bytes without start
    s0 = nstrobe;
    i2c_start();
    send_byte(8'h54, 0, a0); send_byte(SUB, 0, a1);
    i2c_stop();
    m_scl = 0; tick(Q);
    send_byte(8'h77, 0, a2);
    i2c_stop();
    chk("R3 stop ends transfer", a2, 0);
    chk("R3 no strobe after stop", nstrobe - s0, 0);

    // R2: SDA spike while SCL high in idle starts nothing
    m_scl = 1; m_sda = 1; tick(H);
    g_sda = 1; tick(2); g_sda = 0; tick(H);
    m_scl = 0; tick(Q);
    send_byte(8'h54, 0, a0);
    i2c_stop();
    chk("R2 sda spike no start", a0, 0);

    // R2: SCL spike inside a byte adds no bit
    s0 = nstrobe;
    i2c_start();
    send_byte(8'h54, 1, a0); send_byte(SUB, 1, a1); send_byte(8'h5A, 1, a2);
    i2c_stop();
    chk("R2 scl spike dev ack", a0, 1);
    chk("R2 scl spike data", last_data, 8'h5A);
    chk("R2 scl spike strobe", nstrobe - s0, 1);

    chk("R6 strobe one cycle", dbl, 0);
    chk("R9 released at end", sda_pull, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule